// File: doc/BRIEF.md
# Chip-Select Strobe Timing Generator

This block drives the control strobes of one external memory chip select during a single access. A requester presents a start request with a read/write flag. The block accepts it when it is idle. From then on it counts functional-clock ticks from zero. Chip-select, address-valid, output-enable and write-enable each go low and high again at tick values taken from four timing registers.

The block signals the moment to sample read data with a one-cycle capture pulse. It raises a done pulse on the last tick of the access and then returns to idle. When the synchronous mode for the current direction is on, it also marks each rising edge of a device clock. That clock is the functional clock divided by 1 to 4.

The timing words and mode inputs are sampled once, when the request is accepted. Software may rewrite them while an access is running without disturbing it. The request side is a valid/ready pair. `req_ready` is high exactly when the block is idle. A request held valid while the block is busy stays pending and is taken in the first idle cycle. The requester must keep `req_write` stable while `req_valid` is high and not accepted.

Top module: `memcs_timing_gen`

## Requirements
- R1: Out of reset and whenever idle, `cs_n`, `adv_n`, `oe_n` and `we_n` are high, `req_ready` is high, and `rd_capture`, `done` and `dev_clk_tick` are low.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The first cycle after that edge is tick 0 of the access, and `req_ready` stays low from tick 0 through the done tick.
- R3: `cs_n` is low on ticks t with on <= t < off. The on tick is `cfg_cs[3:0]`. The off tick is `cfg_cs[12:8]` for reads and `cfg_cs[20:16]` for writes.
- R4: `adv_n` follows the same rule with `cfg_adv[3:0]` as its on tick, `cfg_adv[12:8]` as its read off tick and `cfg_adv[20:16]` as its write off tick.
- R5: On reads, `oe_n` is low for on `cfg_strb[3:0]` <= t < off `cfg_strb[12:8]`, and `we_n` stays high. On writes, `we_n` is low for on `cfg_strb[19:16]` <= t < off `cfg_strb[28:24]`, and `oe_n` stays high.
- R6: A strobe whose on tick is not less than its selected off tick stays high for the whole access.
- R7: On reads, `rd_capture` pulses for one cycle on the tick equal to `cfg_cyc[20:16]`. It never pulses on writes, and it does not pulse when that tick lies beyond the cycle time.
- R8: `done` pulses on the tick equal to the cycle time, which is `cfg_cyc[4:0]` for reads and `cfg_cyc[12:8]` for writes. The cycle after it is idle. A cycle time of 0 gives a one-tick access.
- R9: When `sync_rd` (for reads) or `sync_wr` (for writes) is set, `dev_clk_tick` is high on ticks that are multiples of D = `clk_div` + 1. When the flag for the current direction is clear, `dev_clk_tick` stays low.
- R10: Changing the timing or mode inputs after acceptance has no effect on the running access.
- R11: A request held valid across the done tick is accepted after exactly one idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock; one tick per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start request valid |
| req_ready | output | 1 | High when idle and able to accept a request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| cfg_cs | input | 32 | Chip-select on tick and read/write off ticks |
| cfg_adv | input | 32 | Address-valid on tick and read/write off ticks |
| cfg_strb | input | 32 | Output-enable and write-enable on/off ticks |
| cfg_cyc | input | 32 | Read cycle, write cycle and access ticks |
| sync_rd | input | 1 | Synchronous mode for reads |
| sync_wr | input | 1 | Synchronous mode for writes |
| clk_div | input | 2 | Device clock divider minus one |
| cs_n | output | 1 | Chip select, active low |
| adv_n | output | 1 | Address valid, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| rd_capture | output | 1 | One-cycle read data capture pulse |
| done | output | 1 | One-cycle end-of-access pulse |
| dev_clk_tick | output | 1 | Rising-edge marker of the divided device clock |

## Verification
Two pairs of events can fall in the same cycle. The capture pulse and the done pulse coincide when the access tick equals the cycle time. The done tick of one access also meets a pending next request when `req_valid` is held high across it. Table vectors set access equal to cycle time, including a zero-length access, and each tick is compared against strobe windows computed from the register fields. A directed test holds the request valid through the done tick and checks that exactly one idle cycle separates the two accesses.

// File: rtl/memcs_pkg.sv
package memcs_pkg;
  // tick counter width: widest timing field is 5 bits
  localparam int CW = 5;
  // narrow "on" fields are 4 bits
  localparam int ONW = 4;

  // field positions that the decoder relies on
  localparam int ON_LSB     = 0;
  localparam int RD_OFF_LSB = 8;
  localparam int WR_OFF_LSB = 16;
  localparam int WE_ON_LSB  = 16;
  localparam int WE_OFF_LSB = 24;
  localparam int RD_CYC_LSB = 0;
  localparam int WR_CYC_LSB = 8;
  localparam int ACC_LSB    = 16;

  localparam int NSTRB = 4;
  localparam int S_CS  = 0;
  localparam int S_ADV = 1;
  localparam int S_OE  = 2;
  localparam int S_WE  = 3;

  // resolved per-access timing, direction already applied
  typedef struct packed {
    logic [NSTRB-1:0][CW-1:0] on_t;
    logic [NSTRB-1:0][CW-1:0] off_t;
    logic [CW-1:0]            acc;
    logic [CW-1:0]            cyc;
    logic                     cap_en;
    logic                     sync;
    logic [1:0]               div;
  } plan_t;
endpackage

// File: rtl/memcs_cfg_latch.sv
module memcs_cfg_latch
  import memcs_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             wr,
  input  logic [REG_W-1:0] cfg_cs,
  input  logic [REG_W-1:0] cfg_adv,
  input  logic [REG_W-1:0] cfg_strb,
  input  logic [REG_W-1:0] cfg_cyc,
  input  logic             sync_rd,
  input  logic             sync_wr,
  input  logic [1:0]       clk_div,
  output plan_t            plan
);
  plan_t nxt;

  always_comb begin
    nxt = '0;
    nxt.on_t[S_CS]   = CW'(cfg_cs[ON_LSB +: ONW]);
    nxt.off_t[S_CS]  = wr ? cfg_cs[WR_OFF_LSB +: CW] : cfg_cs[RD_OFF_LSB +: CW];
    nxt.on_t[S_ADV]  = CW'(cfg_adv[ON_LSB +: ONW]);
    nxt.off_t[S_ADV] = wr ? cfg_adv[WR_OFF_LSB +: CW] : cfg_adv[RD_OFF_LSB +: CW];
    // a zero off tick keeps the strobe of the other direction parked high
    nxt.on_t[S_OE]   = CW'(cfg_strb[ON_LSB +: ONW]);
    nxt.off_t[S_OE]  = wr ? '0 : cfg_strb[RD_OFF_LSB +: CW];
    nxt.on_t[S_WE]   = CW'(cfg_strb[WE_ON_LSB +: ONW]);
    nxt.off_t[S_WE]  = wr ? cfg_strb[WE_OFF_LSB +: CW] : '0;
    nxt.acc          = cfg_cyc[ACC_LSB +: CW];
    nxt.cyc          = wr ? cfg_cyc[WR_CYC_LSB +: CW] : cfg_cyc[RD_CYC_LSB +: CW];
    nxt.cap_en       = !wr;
    nxt.sync         = wr ? sync_wr : sync_rd;
    nxt.div          = clk_div;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    plan <= '0;
    else if (load) plan <= nxt;
  end

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_cs, cfg_adv, cfg_strb, cfg_cyc};

  // R10: the plan only moves on an accepted request
  a_r10_plan_held: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(plan));
endmodule

// File: rtl/memcs_seq.sv
module memcs_seq
  import memcs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [CW-1:0] cyc,
  output logic          load,
  output logic          busy,
  output logic [CW-1:0] cnt,
  output logic          done
);
  assign req_ready = !busy;
  assign load      = req_valid && !busy;
  assign done      = busy && (cnt == cyc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (done) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt  <= cnt + 1'b1;
    end
  end

  // R2: acceptance starts tick 0 and closes the request side
  a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && cnt == '0));
  // R8: the done tick is followed by an idle cycle
  a_r8_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (req_ready && !done));
endmodule

// File: rtl/memcs_window.sv
module memcs_window
  import memcs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] on_t,
  input  logic [CW-1:0] off_t,
  output logic          strobe_n
);
  assign strobe_n = !(busy && (cnt >= on_t) && (cnt < off_t));

  // R6: an empty window never drives the strobe low
  a_r6_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
    (on_t >= off_t) |-> strobe_n);
endmodule

// File: rtl/memcs_clkdiv.sv
module memcs_clkdiv (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       busy,
  input  logic       sync,
  input  logic [1:0] div,
  output logic       tick
);
  logic [1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase <= '0;
    else if (load)   phase <= '0;
    else if (busy)   phase <= (phase == div) ? 2'd0 : phase + 2'd1;
  end

  assign tick = busy && sync && (phase == 2'd0);

  // R9: with a divider above one, device clock edges never sit on adjacent ticks
  a_r9_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != 2'd0) |=> !tick);
endmodule

// File: rtl/memcs_timing_gen.sv
module memcs_timing_gen
  import memcs_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [REG_W-1:0] cfg_cs,
  input  logic [REG_W-1:0] cfg_adv,
  input  logic [REG_W-1:0] cfg_strb,
  input  logic [REG_W-1:0] cfg_cyc,
  input  logic             sync_rd,
  input  logic             sync_wr,
  input  logic [1:0]       clk_div,
  output logic             cs_n,
  output logic             adv_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             rd_capture,
  output logic             done,
  output logic             dev_clk_tick
);
  plan_t            plan;
  logic             load;
  logic             busy;
  logic [CW-1:0]    cnt;
  logic [NSTRB-1:0] strb_n;

  memcs_cfg_latch #(.REG_W(REG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load), .wr(req_write),
    .cfg_cs(cfg_cs), .cfg_adv(cfg_adv), .cfg_strb(cfg_strb), .cfg_cyc(cfg_cyc),
    .sync_rd(sync_rd), .sync_wr(sync_wr), .clk_div(clk_div), .plan(plan)
  );

  memcs_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .cyc(plan.cyc), .load(load), .busy(busy), .cnt(cnt), .done(done)
  );

  for (genvar g = 0; g < NSTRB; g++) begin : g_strb
    memcs_window u_win (
      .clk(clk), .rst_n(rst_n), .busy(busy), .cnt(cnt),
      .on_t(plan.on_t[g]), .off_t(plan.off_t[g]), .strobe_n(strb_n[g])
    );
  end

  memcs_clkdiv u_div (
    .clk(clk), .rst_n(rst_n), .load(load), .busy(busy),
    .sync(plan.sync), .div(plan.div), .tick(dev_clk_tick)
  );

  assign cs_n       = strb_n[S_CS];
  assign adv_n      = strb_n[S_ADV];
  assign oe_n       = strb_n[S_OE];
  assign we_n       = strb_n[S_WE];
  assign rd_capture = busy && plan.cap_en && (cnt == plan.acc);

  // R1: an idle block keeps every strobe parked high
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && adv_n && oe_n && we_n && !rd_capture && !done));
  // R5: read and write enables are never low together
  a_r5_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));
  // R7: capture never coincides with an active write enable
  a_r7_capture_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |-> we_n);
endmodule

// File: tb/memcs_timing_gen_tb.sv
`timescale 1ns/1ps
module memcs_timing_gen_tb;
  typedef struct packed {
    logic        wr;
    logic        sr;
    logic        sw;
    logic [1:0]  dv;
    logic [31:0] rcs;
    logic [31:0] radv;
    logic [31:0] rstb;
    logic [31:0] rcyc;
    logic [5:0]  edone;
    logic [5:0]  ecap;   // 63 = no capture expected
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 1'b0, 1'b0, 2'd0, 32'h000A0801, 32'h00040300, 32'h09030802, 32'h00060C0A, 6'd10, 6'd6},
    '{1'b1, 1'b0, 1'b0, 2'd0, 32'h000A0801, 32'h00040300, 32'h09030802, 32'h00060C0A, 6'd12, 6'd63},
    '{1'b0, 1'b1, 1'b0, 2'd2, 32'h00050500, 32'h00020200, 32'h04010501, 32'h00050505, 6'd5,  6'd5},
    '{1'b0, 1'b0, 1'b0, 2'd0, 32'h00030307, 32'h00000000, 32'h00000505, 32'h00090404, 6'd4,  6'd63},
    '{1'b1, 1'b0, 1'b1, 2'd0, 32'h00060001, 32'h00020000, 32'h05020400, 32'h00000701, 6'd7,  6'd63},
    '{1'b0, 1'b1, 1'b0, 2'd3, 32'h00000100, 32'h00000000, 32'h00000100, 32'h00000000, 6'd0,  6'd0},
    '{1'b1, 1'b1, 1'b0, 2'd1, 32'h000A0801, 32'h00040300, 32'h09030802, 32'h00060C0A, 6'd12, 6'd63}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [31:0] cfg_cs = '0, cfg_adv = '0, cfg_strb = '0, cfg_cyc = '0;
  logic sync_rd = 1'b0, sync_wr = 1'b0;
  logic [1:0] clk_div = '0;
  logic cs_n, adv_n, oe_n, we_n, rd_capture, done, dev_clk_tick;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  memcs_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .cfg_cs(cfg_cs), .cfg_adv(cfg_adv), .cfg_strb(cfg_strb),
    .cfg_cyc(cfg_cyc), .sync_rd(sync_rd), .sync_wr(sync_wr), .clk_div(clk_div),
    .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n), .we_n(we_n),
    .rd_capture(rd_capture), .done(done), .dev_clk_tick(dev_clk_tick)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
    end
  endtask

  function automatic bit in_win(input int t, input int on, input int off);
    return (t >= on) && (t < off);
  endfunction

  task automatic drive(input vec_t v);
    req_write = v.wr; sync_rd = v.sr; sync_wr = v.sw; clk_div = v.dv;
    cfg_cs = v.rcs; cfg_adv = v.radv; cfg_strb = v.rstb; cfg_cyc = v.rcyc;
  endtask

  task automatic check_tick(input vec_t v, input int t, input bit scr);
    int cs_on, cs_off, ad_on, ad_off, div;
    bit ecs, ead, eoe, ewe, ecap, edn, etk, sy;
    cs_on  = int'(v.rcs[3:0]);
    cs_off = v.wr ? int'(v.rcs[20:16]) : int'(v.rcs[12:8]);
    ad_on  = int'(v.radv[3:0]);
    ad_off = v.wr ? int'(v.radv[20:16]) : int'(v.radv[12:8]);
    ecs = in_win(t, cs_on, cs_off);
    ead = in_win(t, ad_on, ad_off);
    eoe = !v.wr && in_win(t, int'(v.rstb[3:0]), int'(v.rstb[12:8]));
    ewe = v.wr && in_win(t, int'(v.rstb[19:16]), int'(v.rstb[28:24]));
    ecap = (t == int'(v.ecap));
    edn  = (t == int'(v.edone));
    sy   = v.wr ? v.sw : v.sr;
    div  = int'(v.dv) + 1;
    etk  = sy && (t % div == 0);
    chk(cs_n == !ecs, scr ? "R10" : (cs_on >= cs_off ? "R6" : "R3"), "cs_n", cs_n, !ecs);
    chk(adv_n == !ead, scr ? "R10" : (ad_on >= ad_off ? "R6" : "R4"), "adv_n", adv_n, !ead);
    chk(oe_n == !eoe, scr ? "R10" : "R5", "oe_n", oe_n, !eoe);
    chk(we_n == !ewe, scr ? "R10" : "R5", "we_n", we_n, !ewe);
    chk(rd_capture == ecap, "R7", "rd_capture", rd_capture, ecap);
    chk(done == edn, "R8", "done", done, edn);
    chk(dev_clk_tick == etk, "R9", "dev_clk_tick", dev_clk_tick, etk);
    chk(req_ready == 1'b0, "R2", "req_ready busy", req_ready, 0);
  endtask

  task automatic run_vec(input vec_t v, input bit scr);
    @(negedge clk);
    drive(v);
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R2", "req_ready idle", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int t = 0; t <= int'(v.edone); t++) begin
      check_tick(v, t, scr);
      if (scr && t == 2) begin
        cfg_cs = 32'h1F1F1F1F; cfg_adv = 32'h1F1F1F1F;
        cfg_strb = 32'h1F1F1F1F; cfg_cyc = 32'h1F1F1F1F;
        req_write = ~req_write; sync_rd = ~sync_rd; sync_wr = ~sync_wr;
      end
      if (t < int'(v.edone)) @(negedge clk);
    end
    @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0, "R8", "idle after done", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cs_n && adv_n && oe_n && we_n, "R1", "strobes in reset", {cs_n, adv_n, oe_n, we_n}, 15);
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    chk(!rd_capture && !done && !dev_clk_tick, "R1", "pulses in reset",
        {rd_capture, done, dev_clk_tick}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && adv_n && oe_n && we_n && req_ready, "R1", "idle after reset",
        {cs_n, adv_n, oe_n, we_n, req_ready}, 31);

    foreach (VECS[i]) run_vec(VECS[i], 1'b0);

    // R10: timing inputs rewritten mid-access
    run_vec(VECS[0], 1'b1);

    // R11: request held valid through the done tick
    @(negedge clk);
    drive(VECS[1]);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    for (int t = 0; t < 12; t++) @(negedge clk);
    chk(done == 1'b1, "R11", "first done", done, 1);
    @(negedge clk);
    chk(req_ready == 1'b1 && cs_n == 1'b1, "R11", "one idle gap", req_ready, 1);
    @(negedge clk);
    chk(req_ready == 1'b0, "R11", "second accepted", req_ready, 0);
    chk(cs_n == 1'b1 && adv_n == 1'b0, "R11", "second tick0 strobes", {cs_n, adv_n}, 2);
    req_valid = 1'b0;
    for (int t = 1; t <= 12; t++) @(negedge clk);
    chk(done == 1'b1, "R11", "second done", done, 1);
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "idle at end", req_ready, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule